// File: doc/BRIEF.md
# Dual Cascadable Event Counter

The block counts edges on two external event inputs. Each input is first resynchronised to the block clock and then passed through an edge detector. The active edge of each input is chosen by its own polarity bit. Each input drives its own 16-bit counter. Software can chain the two counters into one 32-bit counter. In that mode only the first input counts, and the second counter takes the carry out of the first.

Software reaches the block through a simple byte-wide register bus, with a write strobe and a combinational read port. A control byte holds the two polarity selects, the chaining enable and a snapshot request. Writing the snapshot request copies all four count bytes into a holding register in the same clock. Reads of the count addresses return that holding register, so a multi-byte value read over several bus cycles is always coherent.

Writes to the count addresses load single bytes of the live counters, which lets software preset or clear them. While such a write is in progress, both counters stop counting, and an edge that lands in that cycle is lost. Polarity should be programmed before the counts are loaded, because changing it can register a spurious edge.

Top module: `evtcnt_top`

## Requirements
- R1: After reset the control byte (address 0x0C) and all four count bytes (0x0D to 0x10) read 0.
- R2: With polarity bit 0 (input A at control bit 0, input B at bit 1) a rising input edge adds one to its counter and a falling edge does not; with the bit at 1 only falling edges count. The live counter changes on the third rising clock edge after the input changes.
- R3: With chaining off (control bit 2 = 0), input A advances only counter A (0x0D low byte, 0x0E high byte) and input B advances only counter B (0x0F low, 0x10 high).
- R4: With chaining on, counter A is the low half and counter B the high half of one 32-bit count fed by input A; counter B advances exactly when counter A wraps from 0xFFFF to 0x0000, and edges on input B have no effect.
- R5: Writing the control byte with bit 3 set captures both counters into the read-holding register in that clock; reads of 0x0D to 0x10 return the held bytes, which do not change until the next capture.
- R6: Control bit 3 reads 1 for exactly one cycle after a capture and reads 0 again afterwards, while bits 0 to 2 keep their written values.
- R7: A write to one count address loads only that byte of the live counter; the other bytes are left unchanged.
- R8: While any count address is being written, neither counter advances, and an edge detected in that cycle is dropped, not deferred.
- R9: With chaining off, a counter at 0xFFFF wraps to 0x0000 on the next counted edge without touching the other counter.
- R10: Addresses other than 0x0C to 0x10 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_a_in | input | 1 | Event input A, asynchronous |
| ev_b_in | input | 1 | Event input B, asynchronous |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The counting path is tried with every combination of the two polarity selects. In each combination the two inputs get different pulse counts, so a swapped counter, a wrong active edge or a counter that counts both edges each gives a wrong total. Chained runs put pulses on both inputs and expect only input A's pulses, which separates a correct chain from one that still listens to input B. Preset values just below the wrap point show whether the carry reaches the upper half, and whether an unchained wrap stays inside its own counter. A write that coincides with a detected edge shows that the edge is dropped, and counts taken after a capture show that the held bytes stay frozen.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  // Byte addresses decoded by the register block
  localparam logic [7:0] CTRL_ADDR = 8'h0C;
  localparam logic [7:0] CNT_BASE  = 8'h0D;

  // Control byte layout; the bit order is decoded by software
  typedef struct packed {
    logic snap;
    logic casc;
    logic pol_b;
    logic pol_a;
  } ctrl_t;
endpackage

// File: rtl/evtcnt_sync_edge.sv
module evtcnt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic falling_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              level;

  assign level = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin_i};
      prev  <= level;
    end
  end

  assign edge_o = falling_i ? (prev & ~level) : (level & ~prev);
endmodule

// File: rtl/evtcnt_core.sv
module evtcnt_core #(
  parameter int CNT_W = 16,
  localparam int BPC  = CNT_W / 8,
  localparam int NB   = 2 * BPC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_a,
  input  logic             edge_b,
  input  logic             casc,
  input  logic             cnt_wr,
  input  logic [NB-1:0]    byte_en,
  input  logic [7:0]       wdata,
  output logic [CNT_W-1:0] cnt_a,
  output logic [CNT_W-1:0] cnt_b,
  output logic             inc_a,
  output logic             inc_b
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic inc);
    return c + {{(CNT_W-1){1'b0}}, inc};
  endfunction

  function automatic logic wraps(input logic [CNT_W-1:0] c, input logic inc);
    return inc && (&c);
  endfunction

  assign inc_a = edge_a & ~cnt_wr;
  assign inc_b = casc ? wraps(cnt_a, inc_a) : (edge_b & ~cnt_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a <= '0;
      cnt_b <= '0;
    end else if (cnt_wr) begin
      for (int i = 0; i < BPC; i++) begin
        if (byte_en[i])       cnt_a[8*i +: 8] <= wdata;
        if (byte_en[BPC + i]) cnt_b[8*i +: 8] <= wdata;
      end
    end else begin
      cnt_a <= step(cnt_a, inc_a);
      cnt_b <= step(cnt_b, inc_b);
    end
  end
endmodule

// File: rtl/evtcnt_regs.sv
module evtcnt_regs
  import evtcnt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  localparam int NB    = 2 * (CNT_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic [CNT_W-1:0]  cnt_a,
  input  logic [CNT_W-1:0]  cnt_b,
  output ctrl_t             ctrl,
  output logic              cnt_wr,
  output logic [NB-1:0]     byte_en,
  output logic              snap_cap,
  output logic [2*CNT_W-1:0] snap_q,
  output logic [7:0]        bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CNT_BASE);

  logic [ADDR_W-1:0] off;
  logic              in_cnt;
  logic              ctrl_wr;

  assign off     = bus_addr - A_BASE;
  assign in_cnt  = (bus_addr >= A_BASE) && (off < ADDR_W'(NB));
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign cnt_wr  = bus_wr && in_cnt;
  assign snap_cap = ctrl_wr && bus_wdata[3];

  for (genvar i = 0; i < NB; i++) begin : g_ben
    assign byte_en[i] = cnt_wr && (off == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      snap_q <= '0;
    end else begin
      ctrl.snap <= snap_cap;
      if (ctrl_wr) begin
        ctrl.casc  <= bus_wdata[2];
        ctrl.pol_b <= bus_wdata[1];
        ctrl.pol_a <= bus_wdata[0];
      end
      if (snap_cap) snap_q <= {cnt_b, cnt_a};
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == A_CTRL) begin
      bus_rdata = {4'b0000, ctrl};
    end else if (in_cnt) begin
      for (int i = 0; i < NB; i++)
        if (off == ADDR_W'(i)) bus_rdata = snap_q[8*i +: 8];
    end
  end
endmodule

// File: rtl/evtcnt_top.sv
module evtcnt_top
  import evtcnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NB         = 2 * (CNT_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_a_in,
  input  logic              ev_b_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  ctrl_t              ctrl;
  logic [1:0]         pins;
  logic [1:0]         pols;
  logic [1:0]         edges;
  logic               edge_a, edge_b;
  logic               inc_a, inc_b;
  logic               cnt_wr, snap_cap, casc, snap_flag;
  logic [NB-1:0]      byte_en;
  logic [CNT_W-1:0]   cnt_a, cnt_b;
  logic [2*CNT_W-1:0] snap_q;

  assign pins      = {ev_b_in, ev_a_in};
  assign pols      = {ctrl.pol_b, ctrl.pol_a};
  assign edge_a    = edges[0];
  assign edge_b    = edges[1];
  assign casc      = ctrl.casc;
  assign snap_flag = ctrl.snap;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    evtcnt_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pins[c]),
      .falling_i(pols[c]),
      .edge_o   (edges[c])
    );
  end

  evtcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .edge_a (edge_a),
    .edge_b (edge_b),
    .casc   (casc),
    .cnt_wr (cnt_wr),
    .byte_en(byte_en),
    .wdata  (bus_wdata),
    .cnt_a  (cnt_a),
    .cnt_b  (cnt_b),
    .inc_a  (inc_a),
    .inc_b  (inc_b)
  );

  evtcnt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .ctrl     (ctrl),
    .cnt_wr   (cnt_wr),
    .byte_en  (byte_en),
    .snap_cap (snap_cap),
    .snap_q   (snap_q),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/evtcnt_checker.sv
module evtcnt_checker #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inc_a,
  input logic               inc_b,
  input logic               casc,
  input logic               cnt_wr,
  input logic               snap_cap,
  input logic               snap_flag,
  input logic [CNT_W-1:0]   cnt_a,
  input logic [CNT_W-1:0]   cnt_b,
  input logic [2*CNT_W-1:0] snap_q
);
  assert_hold_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !inc_a) |=> (cnt_a == $past(cnt_a)));

  assert_step_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_b |=> (cnt_b == $past(cnt_b) + CNT_W'(1)));

  assert_ignore_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !inc_a) |-> !inc_b);

  assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && inc_a && (&cnt_a)) |-> inc_b);

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cap |=> $stable(snap_q));

  assert_selfclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_flag |-> $past(snap_cap));

  assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !(inc_a || inc_b));
endmodule

bind evtcnt_top evtcnt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inc_a    (inc_a),
  .inc_b    (inc_b),
  .casc     (casc),
  .cnt_wr   (cnt_wr),
  .snap_cap (snap_cap),
  .snap_flag(snap_flag),
  .cnt_a    (cnt_a),
  .cnt_b    (cnt_b),
  .snap_q   (snap_q)
);

// File: tb/evtcnt_top_test.sv
module evtcnt_top_test;
  localparam logic [7:0] A_CTRL = 8'h0C;
  localparam logic [7:0] A_ALO  = 8'h0D;
  localparam logic [7:0] A_AHI  = 8'h0E;
  localparam logic [7:0] A_BLO  = 8'h0F;
  localparam logic [7:0] A_BHI  = 8'h10;
  localparam int NV = 6;
  // {pol_a, pol_b, casc, pulses_a[3:0], pulses_b[3:0], exp_a[15:0], exp_b[15:0]}
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd3, 4'd5, 16'd3, 16'd5},
    {1'b1, 1'b0, 1'b0, 4'd2, 4'd1, 16'd2, 16'd1},
    {1'b0, 1'b1, 1'b0, 4'd4, 4'd2, 16'd4, 16'd2},
    {1'b1, 1'b1, 1'b0, 4'd1, 4'd6, 16'd1, 16'd6},
    {1'b0, 1'b0, 1'b1, 4'd3, 4'd4, 16'd3, 16'd0},
    {1'b1, 1'b1, 1'b1, 4'd2, 4'd3, 16'd2, 16'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_a_in = 1'b0, ev_b_in = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] shadow = 3'b000;
  int         errors = 0;
  int         checks = 0;

  evtcnt_top uut (
    .clk(clk), .rst_n(rst_n), .ev_a_in(ev_a_in), .ev_b_in(ev_b_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [7:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 8'd1, h);
    v = {h, l};
  endtask

  task automatic set_ctrl(input logic [2:0] c);
    shadow = c;
    wr(A_CTRL, {5'b0, c});
  endtask

  task automatic snap();
    wr(A_CTRL, {4'b0001, shadow});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit ch, input bit pol);
    if (ch) ev_b_in = ~pol; else ev_a_in = ~pol;
    idle(4);
    if (ch) ev_b_in = pol; else ev_a_in = pol;
    idle(4);
  endtask

  task automatic preset(input logic [15:0] a, input logic [15:0] b);
    wr(A_ALO, a[7:0]); wr(A_AHI, a[15:8]);
    wr(A_BLO, b[7:0]); wr(A_BHI, b[15:8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] va, vb;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state of every register
    for (int a = 12; a <= 16; a++) begin
      rd(8'(a), d);
      check(d == 8'h00, "R1 reset", {24'h0, d}, 32'h0);
    end

    // Table walk: R2 polarity, R3 independence, R4 chained input B ignored
    for (int v = 0; v < NV; v++) begin
      logic pa, pb, cs;
      logic [3:0] na, nb;
      logic [15:0] ea, eb;
      {pa, pb, cs, na, nb, ea, eb} = VEC[v];
      set_ctrl({cs, pb, pa});
      ev_a_in = pa; ev_b_in = pb;
      idle(5);
      preset(16'h0000, 16'h0000);
      for (int k = 0; k < int'(na); k++) pulse(1'b0, pa);
      for (int k = 0; k < int'(nb); k++) pulse(1'b1, pb);
      snap();
      rd16(A_ALO, va);
      rd16(A_BLO, vb);
      check(va == ea, cs ? "R4 chained count A" : "R2 count A", {16'h0, va}, {16'h0, ea});
      check(vb == eb, cs ? "R4 input B ignored" : "R3 count B", {16'h0, vb}, {16'h0, eb});
    end

    // R6: snapshot flag pulse and retained control bits
    set_ctrl(3'b010);
    ev_a_in = 1'b0; ev_b_in = 1'b1;
    idle(5);
    snap();
    rd(A_CTRL, d);
    check(d == 8'h0A, "R6 flag set", {24'h0, d}, 32'h0A);
    idle(1);
    rd(A_CTRL, d);
    check(d == 8'h02, "R6 flag cleared", {24'h0, d}, 32'h02);

    // R7: byte-wise preset
    set_ctrl(3'b000);
    ev_b_in = 1'b0;
    idle(5);
    preset(16'h1234, 16'h5678);
    wr(A_AHI, 8'hAB);
    snap();
    rd16(A_ALO, va);
    rd16(A_BLO, vb);
    check(va == 16'hAB34, "R7 single byte A", {16'h0, va}, 32'hAB34);
    check(vb == 16'h5678, "R7 counter B kept", {16'h0, vb}, 32'h5678);

    // R5: held bytes stay frozen until the next capture
    pulse(1'b0, 1'b0);
    rd16(A_ALO, va);
    check(va == 16'hAB34, "R5 held value frozen", {16'h0, va}, 32'hAB34);
    snap();
    rd16(A_ALO, va);
    check(va == 16'hAB35, "R5 new capture", {16'h0, va}, 32'hAB35);

    // R9: unchained wrap stays within counter A
    preset(16'hFFFF, 16'h0005);
    pulse(1'b0, 1'b0);
    snap();
    rd16(A_ALO, va);
    rd16(A_BLO, vb);
    check(va == 16'h0000, "R9 A wraps", {16'h0, va}, 32'h0);
    check(vb == 16'h0005, "R9 B untouched", {16'h0, vb}, 32'h5);

    // R4: carry from A into B in chained mode
    set_ctrl(3'b100);
    idle(5);
    preset(16'hFFFE, 16'h0012);
    pulse(1'b0, 1'b0);
    pulse(1'b0, 1'b0);
    snap();
    rd16(A_ALO, va);
    rd16(A_BLO, vb);
    check({vb, va} == 32'h0013_0000, "R4 carry", {vb, va}, 32'h0013_0000);

    // R8: edge detected in a count-write cycle is dropped
    set_ctrl(3'b000);
    idle(5);
    preset(16'h0000, 16'h0000);
    ev_a_in = 1'b1;
    idle(2);
    wr(A_BLO, 8'h07);
    idle(4);
    ev_a_in = 1'b0;
    idle(4);
    snap();
    rd16(A_ALO, va);
    rd16(A_BLO, vb);
    check(va == 16'h0000, "R8 edge dropped", {16'h0, va}, 32'h0);
    check(vb == 16'h0007, "R8 write applied", {16'h0, vb}, 32'h7);

    // R10: unmapped addresses
    wr(8'h11, 8'hFF);
    wr(8'h0B, 8'hFF);
    rd(8'h11, d);
    check(d == 8'h00, "R10 unmapped read", {24'h0, d}, 32'h0);
    rd(A_CTRL, d);
    check(d == 8'h00, "R10 control unchanged", {24'h0, d}, 32'h0);
    snap();
    rd16(A_BLO, vb);
    check(vb == 16'h0007, "R10 counter unchanged", {16'h0, vb}, 32'h7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule